// File: doc/BRIEF.md
# NAND Sector Single-Bit ECC Engine

This block protects one 512-byte NAND sector with a 24-bit Hamming-style code. During a program or read, sector bytes stream through a valid/ready port. The block keeps two 12-bit running parities over the stream. Each byte is located by its position since the start of the sector. When the end-of-sector byte is accepted, the finished code is offered as three bytes on a separate valid/ready port.

The code is presented inverted. An erased sector, with every data byte and every stored code byte at all-ones, therefore checks clean. Taking the last code byte clears the parities and returns the block to idle. A start pulse then arms accumulation for the next sector. A start-of-sector marker seen mid-stream restarts the sum, and that byte counts as byte 0.

A separate check port accepts a stored code and a freshly calculated code. One cycle later it registers a verdict, which is one of:
- clean;
- a correctable data bit, with the byte and bit to flip;
- an error inside the stored code only;
- uncorrectable.

Flipping the reported bit in a sector buffer is left to the caller.

Top module: `nand_sector_ecc`

## Requirements
- R1: While reset is applied and right after it, `in_ready`, `code_valid` and `res_valid` are all 0.
- R2: Stream bytes are taken only after an `arm` pulse. Before that `in_ready` stays 0, and offered bytes have no effect on the next code.
- R3: For each data bit at byte position B (0 first) and bit position b, form the 12-bit address A = {B[8:0], b[2:0]}. Raw upper half = XOR of A over all set data bits. Raw lower half = XOR of ~A over all set data bits. The code is the bitwise inverse of {upper, lower}, with the upper half in bits [23:12].
- R4: After the byte flagged `in_eos` is accepted, the code leaves as three bytes, bits [7:0] first and bits [23:16] last. `code_last` is 1 only with the third byte. A byte holds steady while `code_ready` is 0. `in_ready` is 0 while the code is pending.
- R5: Taking the third code byte returns the block to idle with `in_ready` 0. The next sector's code holds no trace of the previous one.
- R6: An accepted byte flagged `in_sos` discards the running parities. That byte becomes byte position 0.
- R7: A sector of 512 bytes of 0xFF yields the code 0xFFFFFF.
- R8: `res_valid` pulses for one cycle, exactly one cycle after `chk_valid`. `res_kind` = 0 (clean) when the two codes are equal.
- R9: Let D = stored XOR calculated. When D[23:12] is the bitwise complement of D[11:0], `res_kind` = 1 (data bit). In that case `res_byte` = D[23:15] and `res_bit` = D[14:12].
- R10: When the R9 pattern decodes to a byte index of at least SECTOR_BYTES, `res_kind` = 3 (uncorrectable).
- R11: When D has exactly one bit set, `res_kind` = 2 (code-only error), and `res_byte` and `res_bit` are 0.
- R12: Any other nonzero D gives `res_kind` = 3, with `res_byte` and `res_bit` 0.
- R13: The result fields hold their values until the next `chk_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start pulse that opens accumulation for a sector |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted when high with in_valid |
| in_data | input | 8 | Stream data byte |
| in_sos | input | 1 | Byte is the first of a sector |
| in_eos | input | 1 | Byte is the last of a sector |
| code_valid | output | 1 | Code byte available |
| code_ready | input | 1 | Consumer takes the code byte |
| code_byte | output | 8 | Current code byte, least significant first |
| code_last | output | 1 | Third and final code byte |
| chk_valid | input | 1 | Codes on the check port are presented |
| chk_stored | input | 24 | Code read back from the spare area |
| chk_calc | input | 24 | Code calculated over the data just read |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_kind | output | 2 | 0 clean, 1 data bit, 2 code only, 3 uncorrectable |
| res_byte | output | 9 | Byte index to correct |
| res_bit | output | 3 | Bit index to correct |

## Verification
The hardest case to reach is an out-of-range byte index. At the default sector size, nine index bits can never reach 512. The bench therefore places a second instance with half the sector size beside the main one. Both instances get the same check-port stimulus, so one complement pattern is corrected by the full-size instance and rejected by the half-size one. Single-bit data errors are not hand-crafted syndromes. They come from two sectors that differ in one bit, each run through the bench's own parity model, so the byte and bit at the sector edges are covered.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int DATA_W     = 8;
  localparam int POS_W      = $clog2(DATA_W);
  localparam int BYTE_IDX_W = 9;
  localparam int HALF_W     = BYTE_IDX_W + POS_W;
  localparam int CODE_W     = 2 * HALF_W;
  localparam int CODE_BYTES = CODE_W / DATA_W;
  localparam int SEL_W      = $clog2(CODE_BYTES);

  typedef enum logic [1:0] {
    RES_CLEAN    = 2'd0,
    RES_DATA_FIX = 2'd1,
    RES_CODE_FIX = 2'd2,
    RES_FAIL     = 2'd3
  } res_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_OUT  = 2'd2
  } run_state_e;

  // Data bits of a byte whose bit position has bit k equal to want.
  function automatic logic [DATA_W-1:0] pos_mask(input int k, input logic want);
    logic [DATA_W-1:0] m;
    for (int j = 0; j < DATA_W; j++) m[j] = (((j >> k) & 1) == 1) == want;
    return m;
  endfunction
endpackage

// File: rtl/nand_ecc_parity_acc.sv
module nand_ecc_parity_acc
  import nand_ecc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  step,
  input  logic                  restart,
  input  logic [BYTE_IDX_W-1:0] addr,
  input  logic [DATA_W-1:0]     data,
  output logic [CODE_W-1:0]     raw
);
  logic [HALF_W-1:0] hi_q, lo_q, hi_d, lo_d, hi_c, lo_c;
  logic              byte_par;

  assign byte_par = ^data;

  // Per-byte contribution: position parities in the low bits, address above.
  for (genvar k = 0; k < HALF_W; k++) begin : g_par
    if (k < POS_W) begin : g_pos
      assign hi_c[k] = ^(data & pos_mask(k, 1'b1));
      assign lo_c[k] = ^(data & pos_mask(k, 1'b0));
    end else begin : g_adr
      assign hi_c[k] = byte_par &  addr[k-POS_W];
      assign lo_c[k] = byte_par & ~addr[k-POS_W];
    end
  end

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (clear) begin
      hi_d = '0;
      lo_d = '0;
    end else if (restart) begin
      hi_d = hi_c;
      lo_d = lo_c;
    end else if (step) begin
      hi_d = hi_q ^ hi_c;
      lo_d = lo_q ^ lo_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (clear || step) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign raw = {hi_q, lo_q};
endmodule

// File: rtl/nand_ecc_classify.sv
module nand_ecc_classify
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  chk_valid,
  input  logic [CODE_W-1:0]     chk_stored,
  input  logic [CODE_W-1:0]     chk_calc,
  output logic                  res_valid,
  output logic [1:0]            res_kind,
  output logic [BYTE_IDX_W-1:0] res_byte,
  output logic [POS_W-1:0]      res_bit
);
  localparam logic [BYTE_IDX_W:0] LIMIT = (BYTE_IDX_W+1)'(SECTOR_BYTES);

  logic [CODE_W-1:0]     diff;
  logic                  is_zero, is_compl, is_single, in_range;
  logic [BYTE_IDX_W-1:0] idx_byte, byte_d;
  logic [POS_W-1:0]      idx_bit, bit_d;
  res_kind_e             kind_d;

  assign diff      = chk_stored ^ chk_calc;
  assign is_zero   = (diff == '0);
  assign is_compl  = (diff[CODE_W-1:HALF_W] == ~diff[HALF_W-1:0]);
  assign is_single = !is_zero && ((diff & (diff - CODE_W'(1))) == '0);
  assign idx_byte  = diff[CODE_W-1 -: BYTE_IDX_W];
  assign idx_bit   = diff[HALF_W+POS_W-1:HALF_W];
  assign in_range  = ({1'b0, idx_byte} < LIMIT);

  always_comb begin
    kind_d = RES_FAIL;
    byte_d = '0;
    bit_d  = '0;
    if (is_zero) begin
      kind_d = RES_CLEAN;
    end else if (is_compl) begin
      if (in_range) begin
        kind_d = RES_DATA_FIX;
        byte_d = idx_byte;
        bit_d  = idx_bit;
      end
    end else if (is_single) begin
      kind_d = RES_CODE_FIX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_kind  <= RES_CLEAN;
      res_byte  <= '0;
      res_bit   <= '0;
    end else begin
      res_valid <= chk_valid;
      if (chk_valid) begin
        res_kind <= kind_d;
        res_byte <= byte_d;
        res_bit  <= bit_d;
      end
    end
  end
endmodule

// File: rtl/nand_sector_ecc.sv
module nand_sector_ecc
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sos,
  input  logic        in_eos,
  output logic        code_valid,
  input  logic        code_ready,
  output logic [7:0]  code_byte,
  output logic        code_last,
  input  logic        chk_valid,
  input  logic [23:0] chk_stored,
  input  logic [23:0] chk_calc,
  output logic        res_valid,
  output logic [1:0]  res_kind,
  output logic [8:0]  res_byte,
  output logic [2:0]  res_bit
);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(CODE_BYTES - 1);

  logic [1:0]            rs_q;
  logic                  rst_l;
  run_state_e            state_q, state_d;
  logic [BYTE_IDX_W-1:0] cnt_q, cnt_d, acc_addr;
  logic [SEL_W-1:0]      sel_q, sel_d;
  logic                  accept, take, done_read, acc_clear;
  logic [CODE_W-1:0]     acc_raw, code_word;

  // Reset asserts at once and releases two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  assign in_ready   = (state_q == ST_RUN);
  assign code_valid = (state_q == ST_OUT);
  assign code_last  = code_valid && (sel_q == LAST_SEL);
  assign accept     = in_valid && in_ready;
  assign take       = code_valid && code_ready;
  assign done_read  = take && (sel_q == LAST_SEL);
  assign acc_clear  = ((state_q == ST_IDLE) && arm) || done_read;
  assign acc_addr   = in_sos ? '0 : cnt_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (arm)              state_d = ST_RUN;
      ST_RUN:  if (accept && in_eos) state_d = ST_OUT;
      ST_OUT:  if (done_read)        state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (state_q == ST_IDLE) cnt_d = '0;
    else if (accept)        cnt_d = in_sos ? BYTE_IDX_W'(1) : cnt_q + BYTE_IDX_W'(1);
  end

  always_comb begin
    sel_d = sel_q;
    if (accept && in_eos) sel_d = '0;
    else if (take)        sel_d = sel_q + SEL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sel_q   <= sel_d;
    end
  end

  nand_ecc_parity_acc u_acc (
    .clk     (clk),
    .rst_n   (rst_l),
    .clear   (acc_clear),
    .step    (accept),
    .restart (accept && in_sos),
    .addr    (acc_addr),
    .data    (in_data),
    .raw     (acc_raw)
  );

  assign code_word = ~acc_raw;

  always_comb begin
    case (sel_q)
      2'd0:    code_byte = code_word[7:0];
      2'd1:    code_byte = code_word[15:8];
      default: code_byte = code_word[23:16];
    endcase
  end

  nand_ecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .clk        (clk),
    .rst_n      (rst_l),
    .chk_valid  (chk_valid),
    .chk_stored (chk_stored),
    .chk_calc   (chk_calc),
    .res_valid  (res_valid),
    .res_kind   (res_kind),
    .res_byte   (res_byte),
    .res_bit    (res_bit)
  );
endmodule

// File: rtl/nand_ecc_checker.sv
module nand_ecc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       code_valid,
  input logic       code_ready,
  input logic [7:0] code_byte,
  input logic       code_last,
  input logic       chk_valid,
  input logic       res_valid,
  input logic [1:0] res_kind,
  input logic [8:0] res_byte,
  input logic [2:0] res_bit
);
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && code_valid));

  p_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    code_last |-> code_valid);

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !code_ready) |=> (code_valid && $stable(code_byte) && $stable(code_last)));

  p_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> res_valid);

  p_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !res_valid);

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> ($stable(res_kind) && $stable(res_byte) && $stable(res_bit)));

  p_idx_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind != 2'd1) |-> (res_byte == '0 && res_bit == '0));
endmodule

bind nand_sector_ecc nand_ecc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .code_valid (code_valid),
  .code_ready (code_ready),
  .code_byte  (code_byte),
  .code_last  (code_last),
  .chk_valid  (chk_valid),
  .res_valid  (res_valid),
  .res_kind   (res_kind),
  .res_byte   (res_byte),
  .res_bit    (res_bit)
);

// File: tb/nand_sector_ecc_bench.sv
`timescale 1ns/1ps
module nand_sector_ecc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, in_valid = 1'b0, in_sos = 1'b0, in_eos = 1'b0, code_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic chk_valid = 1'b0;
  logic [23:0] chk_stored = '0, chk_calc = '0;
  logic in_ready, code_valid, code_last, res_valid;
  logic [7:0] code_byte;
  logic [1:0] res_kind;
  logic [8:0] res_byte;
  logic [2:0] res_bit;
  logic s_in_ready, s_code_valid, s_code_last, s_res_valid;
  logic [7:0] s_code_byte;
  logic [1:0] s_res_kind;
  logic [8:0] s_res_byte;
  logic [2:0] s_res_bit;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit ended = 0;
  logic [7:0] sec [512];

  always #4 clk = ~clk;

  nand_sector_ecc u_nand_sector_ecc (
    .clk(clk), .rst_n(rst_n), .arm(arm), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sos(in_sos), .in_eos(in_eos), .code_valid(code_valid),
    .code_ready(code_ready), .code_byte(code_byte), .code_last(code_last),
    .chk_valid(chk_valid), .chk_stored(chk_stored), .chk_calc(chk_calc),
    .res_valid(res_valid), .res_kind(res_kind), .res_byte(res_byte), .res_bit(res_bit));

  // Half-size sector, used through its check port only.
  nand_sector_ecc #(.SECTOR_BYTES(256)) u_nand_sector_ecc_small (
    .clk(clk), .rst_n(rst_n), .arm(1'b0), .in_valid(1'b0), .in_ready(s_in_ready),
    .in_data(8'h00), .in_sos(1'b0), .in_eos(1'b0), .code_valid(s_code_valid),
    .code_ready(1'b0), .code_byte(s_code_byte), .code_last(s_code_last),
    .chk_valid(chk_valid), .chk_stored(chk_stored), .chk_calc(chk_calc),
    .res_valid(s_res_valid), .res_kind(s_res_kind), .res_byte(s_res_byte), .res_bit(s_res_bit));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference code from the address definition of the parities.
  function automatic logic [23:0] model_code();
    logic [11:0] hi = '0, lo = '0;
    for (int i = 0; i < 512; i++)
      for (int j = 0; j < 8; j++)
        if (sec[i][j]) begin
          hi ^= {i[8:0], j[2:0]};
          lo ^= ~{i[8:0], j[2:0]};
        end
    return ~{hi, lo};
  endfunction

  function automatic logic [23:0] mk_diff(input int b, input int bt);
    logic [11:0] a = {b[8:0], bt[2:0]};
    return {a, ~a};
  endfunction

  task automatic fill(input int kind);
    for (int i = 0; i < 512; i++)
      case (kind)
        0: sec[i] = 8'hFF;
        1: sec[i] = 8'((i * 37 + (i >> 3)) ^ 8'h5A);
        2: sec[i] = (i == 300) ? 8'h10 : 8'h00;
        default: sec[i] = 8'((i * 11) ^ 8'hC3);
      endcase
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    chk("R2 in_ready after arm", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic send(input int n, input bit garbage, input bit eos_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = garbage ? 8'(i * 13 + 7) : sec[i];
      in_sos   = (i == 0);
      in_eos   = eos_last && (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sos = 1'b0; in_eos = 1'b0;
  endtask

  task automatic read_code(input logic [23:0] exp, input string req);
    logic [7:0] first;
    chk("R4 code_valid after eos", {31'b0, code_valid}, 32'd1);
    chk("R4 in_ready low while code pending", {31'b0, in_ready}, 32'd0);
    first = code_byte;
    @(negedge clk);
    chk("R4 byte steady under stall", {24'b0, code_byte}, {24'b0, first});
    for (int b = 0; b < 3; b++) begin
      chk(req, {24'b0, code_byte}, {24'b0, exp[8*b +: 8]});
      chk("R4 code_last position", {31'b0, code_last}, {31'b0, b == 2});
      code_ready = 1'b1;
      @(negedge clk);
    end
    code_ready = 1'b0;
    chk("R5 idle after read", {30'b0, code_valid, in_ready}, 32'd0);
  endtask

  task automatic check_pair(input logic [23:0] st, input logic [23:0] ca, input int kind,
                            input int b, input int bt, input int skind, input string req);
    @(negedge clk);
    chk_valid = 1'b1; chk_stored = st; chk_calc = ca;
    @(negedge clk);
    chk_valid = 1'b0; chk_stored = 24'h5A5A5A; chk_calc = 24'h123456;
    chk({req, " R8 res_valid"}, {31'b0, res_valid}, 32'd1);
    chk({req, " kind"}, {30'b0, res_kind}, kind);
    chk({req, " byte"}, {23'b0, res_byte}, b);
    chk({req, " bit"}, {29'b0, res_bit}, bt);
    chk({req, " R10 small kind"}, {30'b0, s_res_kind}, skind);
    @(negedge clk);
    chk("R13 pulse ends", {31'b0, res_valid}, 32'd0);
    chk("R13 fields held", {18'b0, res_kind, res_byte, res_bit}, {18'b0, kind[1:0], b[8:0], bt[2:0]});
  endtask

  task automatic t_reset();
    chk("R1 reset in_ready", {31'b0, in_ready}, 32'd0);
    chk("R1 reset code_valid", {31'b0, code_valid}, 32'd0);
    chk("R1 reset res_valid", {31'b0, res_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset", {29'b0, in_ready, code_valid, res_valid}, 32'd0);
  endtask

  task automatic t_ignore_before_arm();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'hAB; in_sos = 1'b1;
      chk("R2 no ready before arm", {31'b0, in_ready}, 32'd0);
    end
    @(negedge clk); in_valid = 1'b0; in_sos = 1'b0;
    fill(2); do_arm(); send(512, 1'b0, 1'b1);
    read_code(model_code(), "R2 R3 code single bit byte 300");
  endtask

  task automatic t_erased();
    fill(0); do_arm(); send(512, 1'b0, 1'b1);
    read_code(24'hFFFFFF, "R7 erased code");
  endtask

  task automatic t_pattern();
    fill(1); do_arm(); send(512, 1'b0, 1'b1);
    read_code(model_code(), "R3 R5 pattern code");
  endtask

  task automatic t_restart();
    fill(3); do_arm();
    send(40, 1'b1, 1'b0);
    send(512, 1'b0, 1'b1);
    read_code(model_code(), "R6 restart code");
  endtask

  task automatic t_classify();
    logic [23:0] good, bad;
    fill(1); good = model_code();
    check_pair(good, good, 0, 0, 0, 0, "R8 clean");
    sec[300][5] = ~sec[300][5]; bad = model_code();
    check_pair(good, bad, 1, 300, 5, 3, "R9 R10 data bit 300.5");
    fill(1); sec[511][7] = ~sec[511][7]; bad = model_code();
    check_pair(good, bad, 1, 511, 7, 3, "R9 data bit 511.7");
    fill(1); sec[0][0] = ~sec[0][0]; bad = model_code();
    check_pair(good, bad, 1, 0, 0, 1, "R9 data bit 0.0");
    check_pair(24'h0F0F0F ^ mk_diff(255, 6), 24'h0F0F0F, 1, 255, 6, 1, "R10 in range on small");
    check_pair(good ^ 24'h000080, good, 2, 0, 0, 2, "R11 code bit 7");
    check_pair(good ^ 24'h800000, good, 2, 0, 0, 2, "R11 code bit 23");
    fill(1); sec[10][1] = ~sec[10][1]; sec[200][4] = ~sec[200][4]; bad = model_code();
    check_pair(good, bad, 3, 0, 0, 3, "R12 two data bits");
    check_pair(24'h000003, 24'h000000, 3, 0, 0, 3, "R12 two code bits");
  endtask

  initial begin
    t_reset();
    t_ignore_before_arm();
    t_erased();
    t_pattern();
    t_restart();
    t_classify();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !ended) begin
      ended = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule